// File: doc/BRIEF.md
# Compare and Conditional Move Unit

This unit is the execute-stage slice of a 32-bit RISC datapath that handles two groups of operations. The first group is the set-on-less-than family: register against register, or register against a 16-bit immediate, each in a signed and an unsigned flavour. These write 1 or 0 to a destination register. The second group is the pair of conditional moves. Each copies the first source operand to the destination, or leaves the destination untouched, depending on whether the second source register holds zero.

The decoded opcode and function fields, both register values, the two register indices and the immediate are presented every cycle. One clock edge later the unit presents three outputs: a write enable, the destination register index and the 32-bit value to write. Whenever the write enable is low, the index and the value are both driven to zero. A downstream register file can therefore take the three outputs directly.

Top module: `cmpmov_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first instruction is sampled, `wr_en_o` is 0 and `wr_idx_o` and `result_o` are 0.
- R2: opcode 0 with function 0x2a writes 1 to register `rd_idx_i` when `rs_val_i` is less than `rt_val_i` as two's-complement numbers, and writes 0 otherwise.
- R3: opcode 0 with function 0x2b writes 1 to `rd_idx_i` when `rs_val_i` is less than `rt_val_i` as unsigned numbers, and writes 0 otherwise.
- R4: opcode 0x0a sign-extends `imm_i` to 32 bits and writes 1 to register `rt_idx_i` when `rs_val_i` is less than the extended value as a signed number, and writes 0 otherwise.
- R5: opcode 0x0b sign-extends `imm_i` to 32 bits, compares it with `rs_val_i` as unsigned numbers, and writes the 1/0 outcome to `rt_idx_i`.
- R6: For the operand pair 0x00000001 and 0xFFFFFFFF, the signed compares yield 0 and the unsigned compares yield 1.
- R7: opcode 0 with function 0x0a writes `rs_val_i` to `rd_idx_i` when `rt_val_i` is zero. Otherwise it asserts no write.
- R8: opcode 0 with function 0x0b writes `rs_val_i` to `rd_idx_i` when `rt_val_i` is nonzero. Otherwise it asserts no write.
- R9: Any operation whose destination index is 0 asserts no write.
- R10: Any other opcode, or any other function under opcode 0, asserts no write.
- R11: Outputs change only at a rising clock edge. They reflect the inputs sampled at that edge. When no write is asserted, `result_o` and `wr_idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used when the opcode is 0 |
| rt_idx_i | input | 5 | Index of the second source register; destination of the immediate compares |
| rd_idx_i | input | 5 | Destination index for the register-register forms |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| imm_i | input | 16 | Immediate field |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Destination register index (0 when no write) |
| result_o | output | 32 | Value to write (0 when no write) |

## Verification
Every piece of state in this unit sits in the output register, so a wrong decode or compare shows up on the very next edge. It appears as a flipped 0/1 result, a result landing in the wrong destination, or a write enable that should have been suppressed. Bit patterns with the top bit set, such as 1 against all ones and immediates at or above 0x8000, separate the signed path from the unsigned path. They also separate sign-extended immediates from zero-extended ones. Conditional moves are checked with both a zero and a nonzero condition register, so an inverted test shows up as a spurious or missing write.

// File: rtl/cmpmov_pkg.sv
package cmpmov_pkg;
  localparam int unsigned OP_W = 6;
  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0a;
  localparam logic [OP_W-1:0] OPC_SLTIU = 6'h0b;
  localparam logic [OP_W-1:0] FN_SLT    = 6'h2a;
  localparam logic [OP_W-1:0] FN_SLTU   = 6'h2b;
  localparam logic [OP_W-1:0] FN_MOVZ   = 6'h0a;
  localparam logic [OP_W-1:0] FN_MOVN   = 6'h0b;

  typedef enum logic [2:0] {
    K_NONE, K_LT_RR_S, K_LT_RR_U, K_LT_RI_S, K_LT_RI_U, K_MV_Z, K_MV_NZ
  } op_kind_e;
endpackage

// File: rtl/cmpmov_decode.sv
module cmpmov_decode
  import cmpmov_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic [OP_W-1:0] funct_i,
  input  logic [AW-1:0]   rt_idx_i,
  input  logic [AW-1:0]   rd_idx_i,
  output op_kind_e        kind_o,
  output logic            use_imm_o,
  output logic            signed_o,
  output logic [AW-1:0]   dst_o
);
  always_comb begin
    kind_o = K_NONE;
    unique case (opcode_i)
      OPC_REG: begin
        unique case (funct_i)
          FN_SLT:  kind_o = K_LT_RR_S;
          FN_SLTU: kind_o = K_LT_RR_U;
          FN_MOVZ: kind_o = K_MV_Z;
          FN_MOVN: kind_o = K_MV_NZ;
          default: kind_o = K_NONE;
        endcase
      end
      OPC_SLTI:  kind_o = K_LT_RI_S;
      OPC_SLTIU: kind_o = K_LT_RI_U;
      default:   kind_o = K_NONE;
    endcase
  end

  assign use_imm_o = (kind_o == K_LT_RI_S) || (kind_o == K_LT_RI_U);
  assign signed_o  = (kind_o == K_LT_RR_S) || (kind_o == K_LT_RI_S);
  assign dst_o     = use_imm_o ? rt_idx_i : rd_idx_i;
endmodule

// File: rtl/cmpmov_compare.sv
module cmpmov_compare #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             signed_i,
  output logic             lt_o
);
  localparam int unsigned EXT_W = DW - IMM_W;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] b;
  logic [DW:0]   a_w, b_w, diff;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DW-1:0];
    end
  endgenerate

  assign b = use_imm_i ? imm_ext : b_reg_i;

  // One DW+1 subtractor serves both flavours: the extra bit is the sign for
  // signed operands and the borrow for unsigned ones.
  assign a_w  = {signed_i & a_i[DW-1], a_i};
  assign b_w  = {signed_i & b[DW-1], b};
  assign diff = a_w - b_w;
  assign lt_o = diff[DW];
endmodule

// File: rtl/cmpmov_select.sv
module cmpmov_select
  import cmpmov_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  op_kind_e      kind_i,
  input  logic          lt_i,
  input  logic [DW-1:0] rs_val_i,
  input  logic [DW-1:0] rt_val_i,
  input  logic [AW-1:0] dst_i,
  output logic          we_o,
  output logic [AW-1:0] idx_o,
  output logic [DW-1:0] val_o
);
  logic          rt_zero;
  logic          want;
  logic [DW-1:0] raw;

  assign rt_zero = (rt_val_i == '0);

  always_comb begin
    want = 1'b0;
    raw  = '0;
    unique case (kind_i)
      K_LT_RR_S, K_LT_RR_U, K_LT_RI_S, K_LT_RI_U: begin
        want = 1'b1;
        raw  = {{(DW-1){1'b0}}, lt_i};
      end
      K_MV_Z: begin
        want = rt_zero;
        raw  = rs_val_i;
      end
      K_MV_NZ: begin
        want = !rt_zero;
        raw  = rs_val_i;
      end
      default: begin
        want = 1'b0;
        raw  = '0;
      end
    endcase
  end

  assign we_o  = want && (dst_i != '0);
  assign idx_o = we_o ? dst_i : '0;
  assign val_o = we_o ? raw : '0;
endmodule

// File: rtl/cmpmov_unit.sv
module cmpmov_unit
  import cmpmov_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned AW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [5:0]       opcode_i,
  input  logic [5:0]       funct_i,
  input  logic [AW-1:0]    rt_idx_i,
  input  logic [AW-1:0]    rd_idx_i,
  input  logic [DW-1:0]    rs_val_i,
  input  logic [DW-1:0]    rt_val_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_idx_o,
  output logic [DW-1:0]    result_o
);
  op_kind_e      kind;
  logic          use_imm, is_signed, lt;
  logic [AW-1:0] dst, idx_n;
  logic          we_n;
  logic [DW-1:0] val_n;

  cmpmov_decode #(.AW(AW)) u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .rt_idx_i (rt_idx_i),
    .rd_idx_i (rd_idx_i),
    .kind_o   (kind),
    .use_imm_o(use_imm),
    .signed_o (is_signed),
    .dst_o    (dst)
  );

  cmpmov_compare #(.DW(DW), .IMM_W(IMM_W)) u_cmp (
    .a_i      (rs_val_i),
    .b_reg_i  (rt_val_i),
    .imm_i    (imm_i),
    .use_imm_i(use_imm),
    .signed_i (is_signed),
    .lt_o     (lt)
  );

  cmpmov_select #(.DW(DW), .AW(AW)) u_sel (
    .kind_i  (kind),
    .lt_i    (lt),
    .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i),
    .dst_i   (dst),
    .we_o    (we_n),
    .idx_o   (idx_n),
    .val_o   (val_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o  <= 1'b0;
      wr_idx_o <= '0;
      result_o <= '0;
    end else begin
      wr_en_o  <= we_n;
      wr_idx_o <= idx_n;
      result_o <= val_n;
    end
  end
endmodule

// File: rtl/cmpmov_unit_chk.sv
module cmpmov_unit_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned AW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [5:0]       opcode_i,
  input logic [5:0]       funct_i,
  input logic [AW-1:0]    rt_idx_i,
  input logic [AW-1:0]    rd_idx_i,
  input logic [DW-1:0]    rs_val_i,
  input logic [DW-1:0]    rt_val_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             wr_en_o,
  input logic [AW-1:0]    wr_idx_o,
  input logic [DW-1:0]    result_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_no_write_r0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o != '0));

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> (result_o == '0 && wr_idx_o == '0));

  assert_slt_signed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(opcode_i == 6'h00 && funct_i == 6'h2a && rd_idx_i != '0))
    |-> (wr_en_o && wr_idx_o == $past(rd_idx_i) &&
         result_o == DW'($past($signed(rs_val_i) < $signed(rt_val_i)))));

  assert_slt_unsigned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(opcode_i == 6'h00 && funct_i == 6'h2b && rd_idx_i != '0))
    |-> (wr_en_o && result_o == DW'($past(rs_val_i < rt_val_i))));

  assert_imm_binary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past((opcode_i == 6'h0a || opcode_i == 6'h0b) && rt_idx_i != '0))
    |-> (wr_en_o && wr_idx_o == $past(rt_idx_i) && result_o[DW-1:1] == '0));

  assert_movz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(opcode_i == 6'h00 && funct_i == 6'h0a && rd_idx_i != '0))
    |-> (wr_en_o == $past(rt_val_i == '0)));

  assert_movn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(opcode_i == 6'h00 && funct_i == 6'h0b && rd_idx_i != '0 && rt_val_i != '0))
    |-> (wr_en_o && result_o == $past(rs_val_i)));

  assert_unknown_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(opcode_i != 6'h00 && opcode_i != 6'h0a && opcode_i != 6'h0b))
    |-> !wr_en_o);
endmodule

bind cmpmov_unit cmpmov_unit_chk #(.DW(DW), .IMM_W(IMM_W), .AW(AW)) u_chk (.*);

// File: tb/tb_cmpmov_unit.sv
module tb_cmpmov_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [5:0]  funct_i = '0;
  logic [4:0]  rt_idx_i = '0;
  logic [4:0]  rd_idx_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [15:0] imm_i = '0;
  logic        wr_en_o;
  logic [4:0]  wr_idx_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cmpmov_unit dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive between edges, sample just after the capturing edge
  task automatic issue(input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] rs, input logic [31:0] rt,
                       input logic [15:0] imm, input logic [4:0] rti, input logic [4:0] rdi);
    @(negedge clk_i);
    opcode_i = op; funct_i = fn; rs_val_i = rs; rt_val_i = rt;
    imm_i = imm; rt_idx_i = rti; rd_idx_i = rdi;
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_wr(input string req, input logic [4:0] idx, input logic [31:0] val);
    check({req, " we"}, 32'(wr_en_o), 32'd1);
    check({req, " idx"}, 32'(wr_idx_o), 32'(idx));
    check({req, " val"}, result_o, val);
  endtask

  task automatic expect_none(input string req);
    check({req, " we"}, 32'(wr_en_o), 32'd0);
    check({req, " idx"}, 32'(wr_idx_o), 32'd0);
    check({req, " val"}, result_o, 32'd0);
  endtask

  task automatic t_reset_R1;
    opcode_i = 6'h00; funct_i = 6'h0b; rs_val_i = 32'h55; rt_val_i = 32'h1; rd_idx_i = 5'd3;
    repeat (2) @(posedge clk_i);
    #1;
    expect_none("R1 in reset");
  endtask

  task automatic t_slt_R2;
    issue(6'h00, 6'h2a, 32'd5, 32'd7, 16'h0, 5'd9, 5'd4);            expect_wr("R2 5<7", 5'd4, 1);
    issue(6'h00, 6'h2a, 32'd7, 32'd5, 16'h0, 5'd9, 5'd4);            expect_wr("R2 7<5", 5'd4, 0);
    issue(6'h00, 6'h2a, 32'hFFFFFFFD, 32'd2, 16'h0, 5'd9, 5'd6);     expect_wr("R2 -3<2", 5'd6, 1);
    issue(6'h00, 6'h2a, 32'h80000000, 32'h80000000, 16'h0, 5'd1, 5'd6); expect_wr("R2 eq", 5'd6, 0);
  endtask

  task automatic t_sltu_R3;
    issue(6'h00, 6'h2b, 32'd2, 32'hFFFFFFFF, 16'h0, 5'd1, 5'd7);     expect_wr("R3 2<max", 5'd7, 1);
    issue(6'h00, 6'h2b, 32'hFFFFFFFF, 32'd2, 16'h0, 5'd1, 5'd7);     expect_wr("R3 max<2", 5'd7, 0);
    issue(6'h00, 6'h2b, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd1, 5'd8); expect_wr("R3 mid", 5'd8, 1);
  endtask

  task automatic t_pattern_R6;
    issue(6'h00, 6'h2a, 32'd1, 32'hFFFFFFFF, 16'h0, 5'd1, 5'd10);    expect_wr("R6 reg signed", 5'd10, 0);
    issue(6'h00, 6'h2b, 32'd1, 32'hFFFFFFFF, 16'h0, 5'd1, 5'd10);    expect_wr("R6 reg unsigned", 5'd10, 1);
    issue(6'h0a, 6'h00, 32'd1, 32'h0, 16'hFFFF, 5'd11, 5'd0);        expect_wr("R6 imm signed", 5'd11, 0);
    issue(6'h0b, 6'h00, 32'd1, 32'h0, 16'hFFFF, 5'd11, 5'd0);        expect_wr("R6 imm unsigned", 5'd11, 1);
  endtask

  task automatic t_slti_R4;
    issue(6'h0a, 6'h3f, 32'hFFFFFFFB, 32'h0, 16'hFFFF, 5'd12, 5'd2); expect_wr("R4 -5<-1", 5'd12, 1);
    issue(6'h0a, 6'h3f, 32'd100, 32'h0, 16'd50, 5'd12, 5'd2);        expect_wr("R4 100<50", 5'd12, 0);
    issue(6'h0a, 6'h00, 32'd0, 32'h0, 16'h8000, 5'd13, 5'd2);        expect_wr("R4 0<-32768", 5'd13, 0);
  endtask

  task automatic t_sltiu_R5;
    issue(6'h0b, 6'h00, 32'd5, 32'h0, 16'h8000, 5'd14, 5'd0);        expect_wr("R5 5<FFFF8000", 5'd14, 1);
    issue(6'h0b, 6'h00, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd14, 5'd0); expect_wr("R5 eq", 5'd14, 0);
    issue(6'h0b, 6'h00, 32'hFFFF9000, 32'h0, 16'h8000, 5'd15, 5'd0); expect_wr("R5 above", 5'd15, 0);
  endtask

  task automatic t_movz_R7;
    issue(6'h00, 6'h0a, 32'hCAFE0001, 32'h0, 16'h0, 5'd3, 5'd16);    expect_wr("R7 taken", 5'd16, 32'hCAFE0001);
    issue(6'h00, 6'h0a, 32'hCAFE0002, 32'h10, 16'h0, 5'd3, 5'd16);   expect_none("R7 held");
  endtask

  task automatic t_movn_R8;
    issue(6'h00, 6'h0b, 32'hBEEF0003, 32'h80000000, 16'h0, 5'd3, 5'd17); expect_wr("R8 taken", 5'd17, 32'hBEEF0003);
    issue(6'h00, 6'h0b, 32'hBEEF0004, 32'h0, 16'h0, 5'd3, 5'd17);        expect_none("R8 held");
  endtask

  task automatic t_r0_R9;
    issue(6'h00, 6'h2a, 32'd1, 32'd2, 16'h0, 5'd5, 5'd0);            expect_none("R9 slt r0");
    issue(6'h0a, 6'h00, 32'd1, 32'd0, 16'd9, 5'd0, 5'd5);            expect_none("R9 slti r0");
    issue(6'h00, 6'h0a, 32'd77, 32'd0, 16'h0, 5'd5, 5'd0);           expect_none("R9 movz r0");
  endtask

  task automatic t_other_R10;
    issue(6'h00, 6'h20, 32'd1, 32'd2, 16'h0, 5'd5, 5'd6);            expect_none("R10 funct20");
    issue(6'h23, 6'h2a, 32'd1, 32'd2, 16'h0, 5'd5, 5'd6);            expect_none("R10 op23");
    issue(6'h0c, 6'h00, 32'd1, 32'd2, 16'h5, 5'd5, 5'd6);            expect_none("R10 op0c");
  endtask

  task automatic t_timing_R11;
    issue(6'h00, 6'h0b, 32'h12345678, 32'd1, 16'h0, 5'd2, 5'd20);
    @(negedge clk_i);
    opcode_i = 6'h00; funct_i = 6'h2a; rs_val_i = 32'd9; rt_val_i = 32'd1; rd_idx_i = 5'd21;
    #1;
    expect_wr("R11 before edge", 5'd20, 32'h12345678);
    @(posedge clk_i);
    #1;
    expect_wr("R11 after edge", 5'd21, 0);
  endtask

  task automatic t_async_R1;
    issue(6'h00, 6'h2b, 32'd1, 32'd2, 16'h0, 5'd1, 5'd22);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    expect_none("R1 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset_R1();
        @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        expect_none("R1 after release");
        t_slt_R2();
        t_sltu_R3();
        t_pattern_R6();
        t_slti_R4();
        t_sltiu_R5();
        t_movz_R7();
        t_movn_R8();
        t_r0_R9();
        t_other_R10();
        t_timing_R11();
        t_async_R1();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule